// File: doc/BRIEF.md
# Indexed Memory Region Translator

This block stands between a video decoder and external memory. The decoder never handles a full physical address. It names a buffer by a short region index and gives a byte offset inside that region. The block keeps a table of regions on chip. Each entry holds a 32-bit start address, a 32-bit region size and a 2-bit byte-order mode. For each request, the block forms the physical address from the start address plus the offset. It reorders the write data by the region's mode and passes the access to the memory side one clock later, with a valid/ready handshake on both sides.

An access whose offset reaches or passes the region size is blocked and never reaches memory. A region of size zero blocks every access. A blocked access sets a sticky error flag and records the index that caused it. A packed register holds three plane indexes for luma, blue chroma and red chroma. A request can take its index from that register instead of supplying one. Read data coming back from memory is reordered by the mode that travelled with its request as a tag.

The table, the error state and the plane register are reached through an APB-style register port with no wait states. To program an entry, write the index to a pointer register, then write the start address, size and mode registers, which act on the entry the pointer selects.

Top module: `rgn_xlate`

## Requirements
- R1: After reset, mem_valid is 0 and req_ready is 1. Every table entry reads back as start 0, size 0 and mode 0. The error register and the plane register read 0.
- R2: The register map is: 0x00 pointer (index in bits [7:0]); 0x04 start address, 0x08 size and 0x0C mode (bits [1:0]) of the pointed-to entry, each writable and readable; 0x10 error; 0x14 plane indexes.
- R3: An accepted in-bounds request sets mem_valid in the next cycle, with mem_addr = start + offset modulo 2^32 and mem_we equal to the request's write flag.
- R4: A request is blocked when offset >= size. A size of 0 therefore blocks every offset. A blocked request is accepted but produces no mem_valid, and offset = size - 1 still passes.
- R5: At 0x10, bit 0 is a sticky error flag and bits [15:8] hold the index of the first blocked request since the flag was last cleared. Writing 1 to bit 0 clears the flag. If a clear and a new blocked request fall in the same cycle, the flag stays set and bits [15:8] take the new index.
- R6: mem_wdata is req_wdata reordered by the entry's mode. Mode 0 leaves the data unchanged. Mode 1 swaps the two bytes of each 16-bit lane. Mode 2 reverses the four bytes of each 32-bit lane. Mode 3 exchanges the two 32-bit halves. mem_tag carries the mode.
- R7: rsp_data equals mem_rdata reordered by the mode given on mem_rtag, using the same encoding as R6. This path is combinational.
- R8: req_sel picks the index. 0 uses req_idx. 1 uses bits [7:0] of the plane register (luma), 2 uses bits [15:8] (blue chroma) and 3 uses bits [23:16] (red chroma).
- R9: While mem_valid is 1 and mem_ready is 0, mem_valid, mem_addr and mem_wdata hold steady and req_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write |
| paddr | input | 8 | Register byte address |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data |
| pready | output | 1 | Register port ready, always 1 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_sel | input | 2 | Index source: direct or one of three planes |
| req_idx | input | 8 | Direct region index |
| req_off | input | 16 | Byte offset within the region |
| req_we | input | 1 | Write flag |
| req_wdata | input | 64 | Write data in requester byte order |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory side accepts |
| mem_addr | output | 32 | Translated physical address |
| mem_we | output | 1 | Write flag to memory |
| mem_wdata | output | 64 | Reordered write data |
| mem_tag | output | 2 | Byte-order mode travelling with the access |
| mem_rdata | input | 64 | Read data from memory |
| mem_rtag | input | 2 | Mode tag returned with the read data |
| rsp_data | output | 64 | Reordered read data to the requester |

## Verification
Two things can happen in the same clock edge: the error flag can be cleared through the register port, and a new out-of-bounds request can be accepted. The bench provokes this by placing the access phase of a write of 1 to the error register on the same edge as the acceptance of a request to an unprogrammed index. It then reads the error register back and expects the flag still set and the index field showing the new index. A second overlap is memory back-pressure while a further request waits. Here the bench checks that the held access keeps its address and that req_ready stays low until the memory side takes it.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int REG_W  = 32;

  // register byte offsets
  localparam int RA_PTR    = 'h00;
  localparam int RA_BASE   = 'h04;
  localparam int RA_SIZE   = 'h08;
  localparam int RA_MODE   = 'h0C;
  localparam int RA_ERR    = 'h10;
  localparam int RA_PLANES = 'h14;

  typedef enum logic [1:0] {
    SWP_NONE = 2'd0,
    SWP_H16  = 2'd1,
    SWP_W32  = 2'd2,
    SWP_D64  = 2'd3
  } swap_e;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_SIZE = 2'd1,
    FLD_MODE = 2'd2
  } fld_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] size;
    swap_e             mode;
  } entry_t;

  // offset must lie strictly below the region size
  function automatic logic in_range(input logic [ADDR_W-1:0] off,
                                    input logic [ADDR_W-1:0] size);
    return off < size;
  endfunction

  function automatic logic [ADDR_W-1:0] xlate(input logic [ADDR_W-1:0] base,
                                              input logic [ADDR_W-1:0] off);
    return base + off;
  endfunction

  function automatic logic [DATA_W-1:0] swap64(input logic [DATA_W-1:0] d,
                                               input swap_e mode);
    logic [DATA_W-1:0] r;
    r = d;
    case (mode)
      SWP_H16: for (int k = 0; k < DATA_W/16; k++)
                 r[16*k +: 16] = {d[16*k +: 8], d[16*k+8 +: 8]};
      SWP_W32: for (int k = 0; k < DATA_W/32; k++)
                 r[32*k +: 32] = {d[32*k +: 8], d[32*k+8 +: 8],
                                  d[32*k+16 +: 8], d[32*k+24 +: 8]};
      SWP_D64: r = {d[DATA_W/2-1:0], d[DATA_W-1:DATA_W/2]};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rgn_table.sv
module rgn_table
  import rgn_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  fld_e             wr_fld,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rda_idx,
  output entry_t           rda_ent,
  input  logic [IDX_W-1:0] rdb_idx,
  output entry_t           rdb_ent
);

  localparam int NUM = 1 << IDX_W;

  entry_t ents [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_ent
    entry_t ent_q;
    logic   hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (hit) begin
        case (wr_fld)
          FLD_BASE: ent_q.base <= wr_data;
          FLD_SIZE: ent_q.size <= wr_data;
          FLD_MODE: ent_q.mode <= swap_e'(wr_data[1:0]);
          default:  ent_q      <= ent_q;
        endcase
      end
    end
    assign ents[g] = ent_q;
  end

  assign rda_ent = ents[rda_idx];
  assign rdb_ent = ents[rdb_idx];

endmodule

// File: rtl/rgn_regs.sv
module rgn_regs
  import rgn_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int PADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [REG_W-1:0]   pwdata,
  output logic [REG_W-1:0]   prdata,
  output logic               pready,
  input  entry_t             cur_ent,
  output logic [IDX_W-1:0]   ptr,
  output logic               tbl_we,
  output fld_e               tbl_fld,
  output logic [REG_W-1:0]   tbl_data,
  output logic [3*IDX_W-1:0] planes,
  input  logic               blk_evt,
  input  logic [IDX_W-1:0]   blk_idx,
  output logic               err_flag,
  output logic [IDX_W-1:0]   err_idx,
  output logic               err_clr_hit
);

  localparam int PL_W = 3 * IDX_W;

  logic wr;
  logic hit_ptr, hit_base, hit_size, hit_mode, hit_err, hit_pl;

  assign wr       = psel && penable && pwrite;
  assign hit_ptr  = paddr == PADDR_W'(RA_PTR);
  assign hit_base = paddr == PADDR_W'(RA_BASE);
  assign hit_size = paddr == PADDR_W'(RA_SIZE);
  assign hit_mode = paddr == PADDR_W'(RA_MODE);
  assign hit_err  = paddr == PADDR_W'(RA_ERR);
  assign hit_pl   = paddr == PADDR_W'(RA_PLANES);
  assign pready   = 1'b1;

  assign tbl_we   = wr && (hit_base || hit_size || hit_mode);
  assign tbl_fld  = hit_base ? FLD_BASE : (hit_size ? FLD_SIZE : FLD_MODE);
  assign tbl_data = pwdata;

  assign err_clr_hit = wr && hit_err && pwdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      planes <= '0;
    end else if (wr) begin
      if (hit_ptr) ptr    <= pwdata[IDX_W-1:0];
      if (hit_pl)  planes <= pwdata[PL_W-1:0];
    end
  end

  // a new blocked access outranks a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_idx  <= '0;
    end else if (blk_evt && (!err_flag || err_clr_hit)) begin
      err_flag <= 1'b1;
      err_idx  <= blk_idx;
    end else if (err_clr_hit) begin
      err_flag <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (hit_ptr)  prdata[IDX_W-1:0] = ptr;
    if (hit_base) prdata = cur_ent.base;
    if (hit_size) prdata = cur_ent.size;
    if (hit_mode) prdata[1:0] = cur_ent.mode;
    if (hit_err) begin
      prdata[0]         = err_flag;
      prdata[8 +: IDX_W] = err_idx;
    end
    if (hit_pl)   prdata[PL_W-1:0] = planes;
  end

endmodule

// File: rtl/rgn_lookup.sv
module rgn_lookup
  import rgn_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int OFF_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_sel,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic [OFF_W-1:0]   req_off,
  input  logic               req_we,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [3*IDX_W-1:0] planes,
  output logic [IDX_W-1:0]   lk_idx,
  input  entry_t             lk_ent,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_we,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [1:0]         mem_tag,
  output logic               acc_ok,
  output logic               acc_blk
);

  logic              accept, pass;
  logic [ADDR_W-1:0] off_x;

  always_comb begin
    case (req_sel)
      2'd0:    lk_idx = req_idx;
      2'd1:    lk_idx = planes[0       +: IDX_W];
      2'd2:    lk_idx = planes[IDX_W   +: IDX_W];
      default: lk_idx = planes[2*IDX_W +: IDX_W];
    endcase
  end

  assign off_x     = ADDR_W'(req_off);
  assign pass      = in_range(off_x, lk_ent.size);
  assign req_ready = !mem_valid || mem_ready;
  assign accept    = req_valid && req_ready;
  assign acc_ok    = accept && pass;
  assign acc_blk   = accept && !pass;

  // blocked requests are consumed without occupying the stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      mem_tag   <= '0;
    end else if (acc_ok) begin
      mem_valid <= 1'b1;
      mem_addr  <= xlate(lk_ent.base, off_x);
      mem_we    <= req_we;
      mem_wdata <= swap64(req_wdata, lk_ent.mode);
      mem_tag   <= lk_ent.mode;
    end else if (accept || mem_ready) begin
      mem_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rgn_xlate.sv
module rgn_xlate
  import rgn_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int OFF_W   = 16,
  parameter int PADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [REG_W-1:0]   pwdata,
  output logic [REG_W-1:0]   prdata,
  output logic               pready,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_sel,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic [OFF_W-1:0]   req_off,
  input  logic               req_we,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_we,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [1:0]         mem_tag,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic [1:0]         mem_rtag,
  output logic [DATA_W-1:0]  rsp_data
);

  entry_t             cur_ent, lk_ent;
  logic [IDX_W-1:0]   ptr, lk_idx, err_idx;
  logic               tbl_we;
  fld_e               tbl_fld;
  logic [REG_W-1:0]   tbl_data;
  logic [3*IDX_W-1:0] planes;
  logic               acc_ok, acc_blk;
  logic               err_flag, err_clr_hit;

  rgn_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_idx  (ptr),
    .wr_fld  (tbl_fld),
    .wr_data (tbl_data),
    .rda_idx (ptr),
    .rda_ent (cur_ent),
    .rdb_idx (lk_idx),
    .rdb_ent (lk_ent)
  );

  rgn_regs #(.IDX_W(IDX_W), .PADDR_W(PADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .pwdata      (pwdata),
    .prdata      (prdata),
    .pready      (pready),
    .cur_ent     (cur_ent),
    .ptr         (ptr),
    .tbl_we      (tbl_we),
    .tbl_fld     (tbl_fld),
    .tbl_data    (tbl_data),
    .planes      (planes),
    .blk_evt     (acc_blk),
    .blk_idx     (lk_idx),
    .err_flag    (err_flag),
    .err_idx     (err_idx),
    .err_clr_hit (err_clr_hit)
  );

  rgn_lookup #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_sel   (req_sel),
    .req_idx   (req_idx),
    .req_off   (req_off),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .planes    (planes),
    .lk_idx    (lk_idx),
    .lk_ent    (lk_ent),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_tag   (mem_tag),
    .acc_ok    (acc_ok),
    .acc_blk   (acc_blk)
  );

  assign rsp_data = swap64(mem_rdata, swap_e'(mem_rtag));

endmodule

// File: rtl/rgn_xlate_chk.sv
module rgn_xlate_chk
  import rgn_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              acc_ok,
  input logic              acc_blk,
  input logic              err_flag,
  input logic              err_clr_hit
);

  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> mem_valid); // R3

  AST_BLOCK_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    acc_blk |=> !mem_valid); // R4

  AST_BLOCK_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_blk |=> err_flag); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr_hit) |=> err_flag); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata))); // R9

  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> !req_ready); // R9

endmodule

bind rgn_xlate rgn_xlate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .acc_ok      (acc_ok),
  .acc_blk     (acc_blk),
  .err_flag    (err_flag),
  .err_clr_hit (err_clr_hit)
);

// File: tb/rgn_xlate_test.sv
module rgn_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic        req_ready;
  logic [1:0]  req_sel = '0;
  logic [7:0]  req_idx = '0;
  logic [15:0] req_off = '0;
  logic [63:0] req_wdata = '0;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = '0, rsp_data;
  logic [1:0]  mem_tag, mem_rtag = '0;

  rgn_xlate uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_idx(req_idx), .req_off(req_off), .req_we(req_we), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_tag(mem_tag),
    .mem_rdata(mem_rdata), .mem_rtag(mem_rtag), .rsp_data(rsp_data)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [63:0] data;
    logic [1:0]  tag;
  } item_t;

  item_t       sbq[$];
  int          total = 0, bad = 0;
  bit          hold = 1'b0, done = 1'b0;
  logic [31:0] m_base [256];
  logic [31:0] m_size [256];
  logic [1:0]  m_mode [256];
  logic [23:0] m_planes = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // byte b of the result comes from byte b^k of the source
  function automatic logic [63:0] ref_swap(input logic [63:0] d, input logic [1:0] m);
    logic [63:0] r;
    int k;
    k = (m == 2'd1) ? 1 : (m == 2'd2) ? 3 : (m == 2'd3) ? 4 : 0;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = d[(b ^ k)*8 +: 8];
    return r;
  endfunction

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic prog(input int i, input logic [31:0] b, input logic [31:0] s, input logic [1:0] m);
    apb_wr(8'h00, 32'(i));
    apb_wr(8'h04, b);
    apb_wr(8'h08, s);
    apb_wr(8'h0C, {30'b0, m});
    m_base[i] = b; m_size[i] = s; m_mode[i] = m;
  endtask

  function automatic int eff_idx(input logic [1:0] sel, input logic [7:0] idx);
    case (sel)
      2'd0: return int'(idx);
      2'd1: return int'(m_planes[7:0]);
      2'd2: return int'(m_planes[15:8]);
      default: return int'(m_planes[23:16]);
    endcase
  endfunction

  // driver: predicts the memory item and pushes it for the monitor
  task automatic send(input logic [1:0] sel, input logic [7:0] idx, input logic [15:0] off,
                      input logic we, input logic [63:0] d);
    int e;
    item_t it;
    e = eff_idx(sel, idx);
    if ({16'b0, off} < m_size[e]) begin
      it.addr = m_base[e] + {16'b0, off};
      it.we = we;
      it.data = ref_swap(d, m_mode[e]);
      it.tag = m_mode[e];
      sbq.push_back(it);
    end
    @(negedge clk);
    req_valid = 1; req_sel = sel; req_idx = idx; req_off = off; req_we = we; req_wdata = d;
    #2;
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  // monitor: pops and compares on every memory handshake
  always begin
    @(negedge clk);
    mem_ready = !hold;
    #1;
    if (rst_n && mem_valid && mem_ready) begin
      if (sbq.size() == 0) begin
        chk(0, "R4 unexpected memory access", {32'b0, mem_addr}, 64'b0);
      end else begin
        item_t x;
        x = sbq.pop_front();
        chk(mem_addr == x.addr, "R3 address", {32'b0, mem_addr}, {32'b0, x.addr});
        chk(mem_we == x.we, "R3 write flag", {63'b0, mem_we}, {63'b0, x.we});
        chk(mem_wdata == x.data, "R6 write data order", mem_wdata, x.data);
        chk(mem_tag == x.tag, "R6 tag", {62'b0, mem_tag}, {62'b0, x.tag});
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  task automatic drain();
    int n = 0;
    while (sbq.size() != 0 && n < 50) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R3 all predicted accesses seen", 64'(sbq.size()), 64'd0);
  endtask

  initial begin : main
    logic [31:0] rd;
    logic [31:0] held;
    for (int i = 0; i < 256; i++) begin
      m_base[i] = '0; m_size[i] = '0; m_mode[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #2;
    chk(mem_valid == 0, "R1 mem_valid after reset", {63'b0, mem_valid}, 64'd0);
    chk(req_ready == 1, "R1 req_ready after reset", {63'b0, req_ready}, 64'd1);
    apb_wr(8'h00, 32'd42);
    apb_rd(8'h04, rd); chk(rd == 0, "R1 start after reset", {32'b0, rd}, 64'd0);
    apb_rd(8'h08, rd); chk(rd == 0, "R1 size after reset", {32'b0, rd}, 64'd0);
    apb_rd(8'h10, rd); chk(rd == 0, "R1 error after reset", {32'b0, rd}, 64'd0);
    apb_rd(8'h14, rd); chk(rd == 0, "R1 planes after reset", {32'b0, rd}, 64'd0);

    prog(5,   32'h1000_0000, 32'h0000_0100, 2'd0);
    prog(9,   32'hFFFF_FF00, 32'h0000_1000, 2'd1);
    prog(200, 32'h0000_2000, 32'h0000_0040, 2'd2);
    prog(255, 32'h8000_0000, 32'h0001_0000, 2'd3);
    apb_wr(8'h00, 32'd9);
    apb_rd(8'h00, rd); chk(rd == 9, "R2 pointer readback", {32'b0, rd}, 64'd9);
    apb_rd(8'h04, rd); chk(rd == 32'hFFFF_FF00, "R2 start readback", {32'b0, rd}, 64'hFFFF_FF00);
    apb_rd(8'h08, rd); chk(rd == 32'h1000, "R2 size readback", {32'b0, rd}, 64'h1000);
    apb_rd(8'h0C, rd); chk(rd == 1, "R2 mode readback", {32'b0, rd}, 64'd1);
    m_planes = 24'hFFC805;
    apb_wr(8'h14, {8'b0, m_planes});
    apb_rd(8'h14, rd); chk(rd == 32'h00FFC805, "R8 plane register", {32'b0, rd}, 64'hFFC805);

    // in-bounds traffic in all four byte orders, including wrap and edge offsets
    send(2'd0, 8'd5,   16'h0010, 1, 64'h0102030405060708);
    send(2'd0, 8'd9,   16'h0200, 1, 64'h1122334455667788);
    send(2'd0, 8'd200, 16'h003F, 1, 64'hA1A2A3A4B1B2B3B4);
    send(2'd0, 8'd255, 16'hFFFF, 0, 64'hC0C1C2C3D0D1D2D3);
    send(2'd1, 8'h33,  16'h00FF, 1, 64'h00000000DEADBEEF); // R8 luma plane, R4 last byte
    send(2'd3, 8'h00,  16'h0020, 1, 64'h0F0E0D0C0B0A0908); // R8 red chroma plane
    send(2'd2, 8'h77,  16'h003F, 0, 64'h1);                // R8 blue chroma plane
    drain();

    // R4 / R5: blocked accesses never reach memory; first index is kept
    send(2'd0, 8'd5, 16'h0100, 1, 64'h55);
    send(2'd2, 8'h00, 16'h0040, 1, 64'h66);
    drain();
    apb_rd(8'h10, rd); chk(rd == 32'h0501, "R5 first blocked index", {32'b0, rd}, 64'h0501);
    send(2'd0, 8'd0, 16'h0000, 0, 64'h0);
    drain();
    apb_rd(8'h10, rd); chk(rd == 32'h0501, "R4 size zero blocked, R5 index kept", {32'b0, rd}, 64'h0501);
    apb_wr(8'h10, 32'h0);
    apb_rd(8'h10, rd); chk(rd == 32'h0501, "R5 writing 0 keeps flag", {32'b0, rd}, 64'h0501);
    apb_wr(8'h10, 32'h1);
    apb_rd(8'h10, rd); chk(rd[0] == 1'b0, "R5 clear by writing 1", {32'b0, rd}, 64'h0);

    // R5: flag set earlier, clear and a new blocked access on the same edge
    send(2'd0, 8'd5, 16'hFFFF, 0, 64'h0);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = 8'h10; pwdata = 32'h1; penable = 0;
    @(negedge clk);
    penable = 1;
    req_valid = 1; req_sel = 2'd0; req_idx = 8'd7; req_off = 16'h0; req_we = 1;
    @(posedge clk);
    #1 req_valid = 0;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
    drain();
    apb_rd(8'h10, rd); chk(rd == 32'h0701, "R5 clear collides with new block", {32'b0, rd}, 64'h0701);

    // R9: back-pressure holds the access and stalls the request side
    hold = 1;
    send(2'd0, 8'd5, 16'h0020, 1, 64'h1234);
    @(negedge clk);
    #2;
    chk(mem_valid == 1, "R3 issued one cycle after accept", {63'b0, mem_valid}, 64'd1);
    held = mem_addr;
    chk(held == 32'h1000_0020, "R3 held address", {32'b0, held}, 64'h1000_0020);
    req_valid = 1; req_sel = 2'd0; req_idx = 8'd9; req_off = 16'h4;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #2;
      chk(mem_valid == 1 && mem_addr == held, "R9 access held under stall", {32'b0, mem_addr}, {32'b0, held});
      chk(req_ready == 0, "R9 ready low under stall", {63'b0, req_ready}, 64'd0);
    end
    req_valid = 0;
    hold = 0;
    drain();

    // R7: read data reordered by returned tag
    for (int m = 0; m < 4; m++) begin
      mem_rdata = 64'h0011223344556677 + 64'(m);
      mem_rtag = 2'(m);
      #1;
      chk(rsp_data == ref_swap(mem_rdata, 2'(m)), "R7 read data order", rsp_data, ref_swap(mem_rdata, 2'(m)));
    end

    finish_run();
  end

endmodule